// File: doc/BRIEF.md
# Integrating Early-Late Bit Phase Detector

This block judges whether a locally generated bit clock sits ahead of or behind an incoming NRZ baseband data stream. It runs on a fast sampling clock that is nominally 20 times the bit rate. The local bit clock and the received data bit arrive as plain inputs and are sampled on that fast clock.

Two signed integrate-and-dump counters accumulate the data, adding one for a sampled 1 and subtracting one for a sampled 0. The in-phase counter's window starts at each rising edge of the local bit clock. The quadrature counter's window starts at each falling edge. After every quadrature window the block compares the two latest results and emits a one-cycle "early" or "late" pulse, or no pulse at all.

No decision is made when the quadrature window saw a data transition at its centre, or when it saw a run of identical bits. No decision is made until a complete in-phase window exists after reset. The pulses are meant to drive a pulse add/delete stage in front of the bit-clock divider, and that stage lies outside this block.

Top module: `early_late_pd`

## Requirements
- R1: While `rst` is high at a clock edge, `early` and `late` are low after that edge, and both integrators and their latched results are cleared to zero.
- R2: The in-phase integrator adds +1 for each sampled `rx_bit` of 1 and -1 for each sampled 0. A rising edge is detected at a `clk` edge where `bit_clk` is sampled 1 and was sampled 0 at the previous edge. At that edge the integrator latches its sum as the in-phase result and restarts from that edge's sample alone.
- R3: The quadrature integrator behaves the same way, but on falling edges. A falling edge is detected where `bit_clk` is sampled 0 and was sampled 1 at the previous edge.
- R4: A quadrature result of 0 produces no pulse.
- R5: A quadrature result of +20 or -20 produces no pulse.
- R6: No pulse appears until two rising edges have been detected since reset, so that one complete in-phase window exists.
- R7: When the in-phase result is nonzero, the quadrature result is not excluded by R4 or R5, and both results have the same sign, the block pulses `early`.
- R8: Under the same conditions as R7 but with opposite signs, the block pulses `late`.
- R9: An in-phase result of 0 that comes from a complete window, together with a quadrature result not excluded by R4 or R5, pulses `early`.
- R10: A decision for a falling edge detected at clock edge k appears on `early` or `late` after edge k+1 and lasts exactly one cycle. The two outputs are never high together, and no pulse appears at any other time.
- R11: Each integrator saturates at +20 and -20, the window length `BIT_TICKS`, so windows longer than a bit neither exceed that bound nor wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock, nominally `BIT_TICKS` times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| bit_clk | input | 1 | Local recovered bit clock, sampled on `clk` |
| rx_bit | input | 1 | Received NRZ data bit, sampled on `clk` |
| early | output | 1 | One-cycle pulse: local clock leads the data |
| late | output | 1 | One-cycle pulse: local clock lags the data |

## Verification
A wrong integrator sum or a window boundary placed one tick off has to shift a quadrature result across 0 or ±20, or flip a sign. When that happens, the error shows as a missing, extra or inverted pulse on the first decision after the fault, one cycle after the next falling edge, and at most one bit period later. A skipped or stuck validity tracker shows up in the first bit period or two after reset as a premature pulse. Missing saturation shows only on a stretched window, where wrap-around inverts the sign of the next decision.

// File: rtl/pd_pkg.sv
package pd_pkg;

  typedef enum logic [1:0] {
    PD_NONE  = 2'd0,
    PD_EARLY = 2'd1,
    PD_LATE  = 2'd2
  } pd_dec_e;

  // Signed width that holds +/-ticks.
  function automatic int cnt_width(input int ticks);
    return $clog2(ticks + 1) + 1;
  endfunction

endpackage

// File: rtl/pd_clock_edges.sv
module pd_clock_edges (
  input  logic clk,
  input  logic rst,
  input  logic bit_clk,
  output logic rise,
  output logic fall,
  output logic ip_valid
);

  logic bclk_q;
  logic seen_rise_q;
  logic valid_q;

  assign rise     = bit_clk & ~bclk_q;
  assign fall     = ~bit_clk & bclk_q;
  assign ip_valid = valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q      <= 1'b0;
      seen_rise_q <= 1'b0;
      valid_q     <= 1'b0;
    end else begin
      bclk_q <= bit_clk;
      if (rise) begin
        seen_rise_q <= 1'b1;
        if (seen_rise_q) valid_q <= 1'b1;
      end
    end
  end

  // R6
  valid_after_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ip_valid) |-> $past(rise));

  // R10
  edges_apart_chk: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);

endmodule

// File: rtl/pd_integrator.sv
module pd_integrator #(
  parameter int BIT_TICKS = 20,
  parameter int W         = pd_pkg::cnt_width(BIT_TICKS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dump,
  input  logic                sample,
  output logic signed [W-1:0] result
);

  localparam logic signed [W-1:0] LIM = W'(BIT_TICKS);
  localparam logic signed [W-1:0] ONE = W'(1);

  logic signed [W-1:0] acc_q;
  logic signed [W-1:0] res_q;

  // Saturating +/-1 step.
  function automatic logic signed [W-1:0] bump(input logic signed [W-1:0] a,
                                                input logic up);
    if (up) return (a >= LIM) ? LIM : a + ONE;
    else    return (a <= -LIM) ? -LIM : a - ONE;
  endfunction

  function automatic logic signed [W-1:0] first_step(input logic up);
    return up ? ONE : -ONE;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      res_q <= '0;
    end else if (dump) begin
      res_q <= acc_q;
      acc_q <= first_step(sample);
    end else begin
      acc_q <= bump(acc_q, sample);
    end
  end

  assign result = res_q;

  // R11
  acc_range_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_q <= LIM) && (acc_q >= -LIM));

  // R2
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    dump |=> (acc_q == ONE) || (acc_q == -ONE));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (acc_q == '0) && (res_q == '0));

endmodule

// File: rtl/pd_decider.sv
module pd_decider #(
  parameter int BIT_TICKS = 20,
  parameter int W         = pd_pkg::cnt_width(BIT_TICKS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                q_done,
  input  logic                ip_valid,
  input  logic signed [W-1:0] ip_res,
  input  logic signed [W-1:0] q_res,
  output logic                early,
  output logic                late
);

  import pd_pkg::*;

  localparam logic signed [W-1:0] LIM = W'(BIT_TICKS);

  logic    early_q, late_q;
  pd_dec_e verdict;

  function automatic pd_dec_e judge(input logic valid,
                                    input logic signed [W-1:0] ip,
                                    input logic signed [W-1:0] q);
    if (!valid)                  return PD_NONE;
    if (q == '0)                 return PD_NONE;
    if (q == LIM || q == -LIM)   return PD_NONE;
    if (ip == '0)                return PD_EARLY;
    if (ip[W-1] ^ q[W-1])        return PD_LATE;
    return PD_EARLY;
  endfunction

  assign verdict = judge(ip_valid, ip_res, q_res);

  always_ff @(posedge clk) begin
    if (rst) begin
      early_q <= 1'b0;
      late_q  <= 1'b0;
    end else begin
      early_q <= q_done && (verdict == PD_EARLY);
      late_q  <= q_done && (verdict == PD_LATE);
    end
  end

  assign early = early_q;
  assign late  = late_q;

  // R10
  no_both_chk: assert property (@(posedge clk) disable iff (rst)
    !(early && late));

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (early || late) |=> !(early || late));

  // R6
  no_early_decision_chk: assert property (@(posedge clk) disable iff (rst)
    !ip_valid |=> !(early || late));

  // R4
  q_zero_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (q_done && q_res == '0) |=> !(early || late));

  // R5
  q_run_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (q_done && (q_res == LIM || q_res == -LIM)) |=> !(early || late));

endmodule

// File: rtl/early_late_pd.sv
module early_late_pd #(
  parameter int BIT_TICKS = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_clk,
  input  logic rx_bit,
  output logic early,
  output logic late
);

  localparam int CW     = pd_pkg::cnt_width(BIT_TICKS);
  localparam int N_INTG = 2;   // 0: in-phase, 1: quadrature

  logic                 rise, fall, ip_valid;
  logic                 q_done_q;
  logic [N_INTG-1:0]    dump_vec;
  logic signed [CW-1:0] res_vec [N_INTG];

  pd_clock_edges u_edges (
    .clk      (clk),
    .rst      (rst),
    .bit_clk  (bit_clk),
    .rise     (rise),
    .fall     (fall),
    .ip_valid (ip_valid)
  );

  assign dump_vec = {fall, rise};

  for (genvar g = 0; g < N_INTG; g++) begin : g_intg
    pd_integrator #(.BIT_TICKS(BIT_TICKS), .W(CW)) u_intg (
      .clk    (clk),
      .rst    (rst),
      .dump   (dump_vec[g]),
      .sample (rx_bit),
      .result (res_vec[g])
    );
  end

  // Quadrature result is readable one cycle after its window closes.
  always_ff @(posedge clk) begin
    if (rst) q_done_q <= 1'b0;
    else     q_done_q <= fall;
  end

  pd_decider #(.BIT_TICKS(BIT_TICKS), .W(CW)) u_dec (
    .clk      (clk),
    .rst      (rst),
    .q_done   (q_done_q),
    .ip_valid (ip_valid),
    .ip_res   (res_vec[0]),
    .q_res    (res_vec[1]),
    .early    (early),
    .late     (late)
  );

  // R10
  pulse_follows_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (early || late) |-> $past(q_done_q));

endmodule

// File: tb/early_late_pd_test.sv
module early_late_pd_test;

  localparam int CLK_PERIOD = 10;
  localparam int BT         = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bclk = 1'b0;
  logic rxb = 1'b0;
  wire  early, late;

  early_late_pd #(.BIT_TICKS(BT)) uut (
    .clk(clk), .rst(rst), .bit_clk(bclk), .rx_bit(rxb),
    .early(early), .late(late)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // reference model state: running sum and sums at edges
  int S, P_rprev, P_rlast, P_flast, rises;
  bit prev_b;
  bit exp_e, exp_l, pend_e, pend_l;
  string exp_tag, pend_tag;
  int hit_r4, hit_r5, hit_r6, hit_r7, hit_r8, hit_r9, hit_r11;
  int tick_no;

  function automatic int clampv(input int v);
    if (v > BT)  return BT;
    if (v < -BT) return -BT;
    return v;
  endfunction

  // 0 none/invalid, 1 none q0, 2 none run, 3 early ip0, 4 early, 5 late
  function automatic int ref_decide(input bit valid, input int ip, input int q);
    if (!valid) return 0;
    if (q == 0) return 1;
    if (q == BT || q == -BT) return 2;
    if (ip == 0) return 3;
    if ((ip > 0) == (q > 0)) return 4;
    return 5;
  endfunction

  task automatic check(input bit e, input bit l, input string tag);
    checks++;
    if ({early, late} !== {e, l}) begin
      fails++;
      $display("FAIL %s tick %0d: early/late=%b%b expected %b%b",
               tag, tick_no, early, late, e, l);
    end
  endtask

  task automatic model_reset();
    S = 0; P_rprev = 0; P_rlast = 0; P_flast = 0; rises = 0;
    prev_b = 1'b0;
    exp_e = 0; exp_l = 0; pend_e = 0; pend_l = 0;
    exp_tag = "R1"; pend_tag = "R10";
  endtask

  task automatic tick(input bit b, input bit r);
    int ipv, qv, raw_ip, code;
    @(negedge clk);
    check(exp_e, exp_l, exp_tag);
    rst = 1'b0; bclk = b; rxb = r; tick_no++;
    exp_e = pend_e; exp_l = pend_l; exp_tag = pend_tag;
    pend_e = 0; pend_l = 0; pend_tag = "R10";
    if (b && !prev_b) begin           // R2 window boundary
      P_rprev = P_rlast; P_rlast = S; rises++;
    end
    if (!b && prev_b) begin           // R3 window boundary
      raw_ip = P_rlast - P_rprev;
      ipv  = clampv(raw_ip);
      qv   = clampv(S - P_flast);
      code = ref_decide(rises >= 2, ipv, qv);
      P_flast = S;
      case (code)
        0: begin pend_tag = "R6"; hit_r6++; end
        1: begin pend_tag = "R4"; hit_r4++; end
        2: begin pend_tag = "R5"; hit_r5++; end
        3: begin pend_tag = "R9"; pend_e = 1; hit_r9++; end
        4: begin pend_tag = "R7/R2/R3"; pend_e = 1; hit_r7++; end
        default: begin pend_tag = "R8/R2/R3"; pend_l = 1; hit_r8++; end
      endcase
      if (code >= 3 && (raw_ip > BT || raw_ip < -BT)) begin
        hit_r11++; pend_tag = "R11";
      end
    end
    S += r ? 1 : -1;
    prev_b = b;
  endtask

  task automatic do_reset();
    @(negedge clk);
    check(exp_e, exp_l, exp_tag);
    rst = 1'b1; bclk = 1'b0; rxb = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(1'b0, 1'b0, "R1");
      rxb = ~rxb;                      // data toggling must not matter in reset
    end
    rxb = 1'b0;
    model_reset();
  endtask

  // mode 0 random, 1 all ones, 2 alternating
  task automatic seg(input int ph, input int hi, input int nbits, input int mode);
    bit d;
    do_reset();
    d = 1'b0;
    for (int t = 0; t < nbits * BT; t++) begin
      if (t % BT == 0) begin
        case (mode)
          0: d = 1'($urandom % 2);
          1: d = 1'b1;
          default: d = ~d;
        endcase
      end
      tick(((t + ph) % BT) < hi, d);
    end
  endtask

  // R11: stretched in-phase window of 40 ones must saturate, not wrap
  task automatic sat_case();
    do_reset();
    for (int p = 0; p < 3; p++)
      for (int t = 0; t < BT; t++) tick(t < 10, 1'b1);
    for (int t = 0; t < 30; t++) tick(1'b1, 1'b1);
    for (int t = 0; t < 10; t++) tick(1'b0, 1'b1);
    for (int t = 0; t < 10; t++) tick(1'b1, t < 5);
    for (int t = 0; t < 12; t++) tick(1'b0, 1'b0);
  endtask

  initial begin
    int ph, hi;
    void'($urandom(32'h1A2B3C4D));
    model_reset();
    tick_no = 0;
    hit_r4 = 0; hit_r5 = 0; hit_r6 = 0; hit_r7 = 0;
    hit_r8 = 0; hit_r9 = 0; hit_r11 = 0;

    seg(0, 10, 12, 2);     // R4: aligned clock, alternating data
    seg(0, 10, 12, 1);     // R5: run of ones
    seg(10, 8, 12, 2);     // R9: in-phase window straddles a transition
    seg(3, 10, 12, 2);     // R7
    seg(17, 10, 12, 2);    // R8
    sat_case();            // R11
    for (int k = 0; k < 16; k++) begin
      ph = int'($urandom % BT);
      case ($urandom % 3)
        0: hi = 8;
        1: hi = 10;
        default: hi = 12;
      endcase
      seg(ph, hi, 40, 0);
    end
    @(negedge clk);
    check(exp_e, exp_l, exp_tag);

    begin : coverage_checks
      string nm [7];
      int    ct [7];
      nm = '{"R4", "R5", "R6", "R7", "R8", "R9", "R11"};
      ct = '{hit_r4, hit_r5, hit_r6, hit_r7, hit_r8, hit_r9, hit_r11};
      for (int i = 0; i < 7; i++) begin
        checks++;
        if (ct[i] == 0) begin
          fails++;
          $display("FAIL %s: case occurrences=0 expected >0", nm[i]);
        end
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: cycles=200000 expected completion earlier");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule